// File: doc/BRIEF.md
# USB Device Reset Sequencer

This block handles reset entry and exit for a full-speed USB device core. A reset can come from two places: a software control bit in the block's register set, or a bus-reset condition reported by the line-state monitor. Both sources do the same thing inside the block. They hold the protocol state machine in its idle state, return the function address and the endpoint registers to zero, and raise a sticky reset-event flag.

Reception and transmission stay gated from the cycle after a reset starts. They reopen only when the reset has ended and software has acknowledged the flag. General configuration is kept through a reset, so the interrupt can be delivered safely and software chooses what to clear. A transaction that completes in the same cycle that a bus reset is detected still has its completion flag posted.

Software sees a small register set: a control word with the reset bit and an interrupt enable, a status word whose flags are cleared by writing zero, the function address, one configuration word, and one word per endpoint.

Top module: `usbdev_rst_seq`

## Requirements
- R1: The software reset bit and the bus-reset input have identical internal effects: protocol reset asserted, reset flag raised, function address and endpoint words cleared, traffic gated.
- R2: `proto_rst` is high in every cycle in which the bus-reset input is high or the software reset bit (control word at address 0, bit 0) is 1. After a write of 0 to that bit, `proto_rst` is low from the following cycle.
- R3: While a reset is active, the function address (address 2, low 7 bits) and every endpoint word (addresses 4 and up, one per endpoint) are held at 0. Writes to them are ignored during that time.
- R4: The configuration word (address 3) and the control word keep their values through any reset event.
- R5: `rx_en` and `tx_en` are 0 from the cycle after a reset source rises. They stay 0 until the reset flag has been cleared and no reset source was active in the previous cycle. Out of power-up reset, both are 1.
- R6: The reset flag (status word at address 1, bit 0) is set on the rising edge of the combined reset source. Writing 0 to that bit clears it. Writing 1 has no effect, and a new rising edge takes priority over a clear in the same cycle.
- R7: `irq` is 1 exactly when the reset flag is 1 and the interrupt enable (control word, bit 1) is 1.
- R8: A pulse on `xfer_ok` while traffic is enabled sets the completion flag (status word, bit 1), including in the cycle in which a bus reset is first detected. That flag is cleared by writing 0 to its bit.
- R9: After power-up reset, every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous power-up reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for read and write |
| wr_data | input | DATA_W | Register write data |
| rd_data | output | DATA_W | Combinational read data at `addr` |
| bus_rst_det | input | 1 | Bus reset condition, already synchronous to `clk` |
| xfer_ok | input | 1 | One-cycle pulse when a transaction completes |
| proto_rst | output | 1 | Holds the protocol state machine idle |
| rx_en | output | 1 | Reception permitted |
| tx_en | output | 1 | Transmission permitted |
| irq | output | 1 | Reset interrupt request |
| faddr_o | output | FADDR_W | Current function address |
| cfg_o | output | DATA_W | General configuration word |
| ep_cfg_o | output | NUM_EP*DATA_W | Endpoint words, endpoint 0 in the low bits |

## Verification
The assertions assume that `bus_rst_det` is already synchronous and free of glitches, and that a write to the configuration address is the only thing allowed to change the configuration word. The stimulus drives the bus-reset input as clean pulses of one to three cycles, with gaps between them. It changes inputs only on falling clock edges, and keeps `xfer_ok` low during the random phase, so the completion flag moves only in the directed case built for it.

// File: rtl/usbdev_rst_pkg.sv
// Package: register addresses and bit positions shared by the reset sequencer,
// its checker and its bench. The endpoint words start at REG_EP_BASE.
package usbdev_rst_pkg;
    localparam int REG_CTRL    = 0;
    localparam int REG_STATUS  = 1;
    localparam int REG_FADDR   = 2;
    localparam int REG_CFG     = 3;
    localparam int REG_EP_BASE = 4;

    localparam int CTRL_SWRST_BIT = 0;
    localparam int CTRL_IRQEN_BIT = 1;
    localparam int STAT_RST_BIT   = 0;
    localparam int STAT_XFER_BIT  = 1;
endpackage

// File: rtl/usbdev_rst_detect.sv
// Combines the two reset sources and finds the first cycle of a reset.
// Assumes bus_rst is already synchronous to clk.
module usbdev_rst_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic bus_rst,
    output logic rst_active,
    output logic rst_event,
    output logic rst_prev
);
    assign rst_active = sw_rst | bus_rst;
    assign rst_event  = rst_active & ~rst_prev;

    // remember the previous cycle's combined source
    always_ff @(posedge clk) begin
        if (!rst_n) rst_prev <= 1'b0;
        else        rst_prev <= rst_active;
    end
endmodule

// File: rtl/usbdev_rst_ctrl_regs.sv
// Holds the control, status, function-address and configuration words.
// The address is cleared while a reset is active. The configuration and
// control words are never touched by a reset event.
module usbdev_rst_ctrl_regs
    import usbdev_rst_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 4,
    parameter int FADDR_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rst_active,
    input  logic               rst_event,
    input  logic               xfer_ok,
    input  logic               traffic_en,
    output logic               sw_rst,
    output logic               irq_en,
    output logic               rst_flag,
    output logic               xfer_flag,
    output logic [FADDR_W-1:0] faddr,
    output logic [DATA_W-1:0]  cfg
);
    logic wr_ctrl, wr_stat, wr_faddr, wr_cfg;

    assign wr_ctrl  = wr_en && (addr == ADDR_W'(REG_CTRL));
    assign wr_stat  = wr_en && (addr == ADDR_W'(REG_STATUS));
    assign wr_faddr = wr_en && (addr == ADDR_W'(REG_FADDR));
    assign wr_cfg   = wr_en && (addr == ADDR_W'(REG_CFG));

    // control word: software reset bit and interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_rst <= 1'b0;
            irq_en <= 1'b0;
        end else if (wr_ctrl) begin
            sw_rst <= wr_data[CTRL_SWRST_BIT];
            irq_en <= wr_data[CTRL_IRQEN_BIT];
        end
    end

    // reset flag: set on a new reset, cleared by writing zero
    always_ff @(posedge clk) begin
        if (!rst_n)                                     rst_flag <= 1'b0;
        else if (rst_event)                             rst_flag <= 1'b1;
        else if (wr_stat && !wr_data[STAT_RST_BIT])     rst_flag <= 1'b0;
    end

    // completion flag: posted while traffic is still open, cleared by writing zero
    always_ff @(posedge clk) begin
        if (!rst_n)                                     xfer_flag <= 1'b0;
        else if (xfer_ok && traffic_en)                 xfer_flag <= 1'b1;
        else if (wr_stat && !wr_data[STAT_XFER_BIT])    xfer_flag <= 1'b0;
    end

    // function address: held at zero during reset
    always_ff @(posedge clk) begin
        if (!rst_n)          faddr <= '0;
        else if (rst_active) faddr <= '0;
        else if (wr_faddr)   faddr <= wr_data[FADDR_W-1:0];
    end

    // configuration word: survives reset events
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg <= '0;
        else if (wr_cfg) cfg <= wr_data;
    end
endmodule

// File: rtl/usbdev_rst_ep_bank.sv
// One register per endpoint, all held at zero while a reset is active.
// Endpoint i sits at address REG_EP_BASE + i.
module usbdev_rst_ep_bank
    import usbdev_rst_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int NUM_EP = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     clear,
    output logic [NUM_EP*DATA_W-1:0] ep_flat
);
    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        logic hit;
        assign hit = wr_en && (addr == ADDR_W'(REG_EP_BASE + g));

        // endpoint word g: cleared by reset, else loaded on write
        always_ff @(posedge clk) begin
            if (!rst_n)     ep_flat[g*DATA_W +: DATA_W] <= '0;
            else if (clear) ep_flat[g*DATA_W +: DATA_W] <= '0;
            else if (hit)   ep_flat[g*DATA_W +: DATA_W] <= wr_data;
        end
    end
endmodule

// File: rtl/usbdev_rst_seq.sv
// Top of the reset sequencer. It ties the source detector, the register
// words and the endpoint bank together, gates traffic, and drives the read
// mux. Assumes bus_rst_det is synchronous and that xfer_ok pulses for one
// cycle per completed transaction.
module usbdev_rst_seq
    import usbdev_rst_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 4,
    parameter int FADDR_W = 7,
    parameter int NUM_EP  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     bus_rst_det,
    input  logic                     xfer_ok,
    output logic                     proto_rst,
    output logic                     rx_en,
    output logic                     tx_en,
    output logic                     irq,
    output logic [FADDR_W-1:0]       faddr_o,
    output logic [DATA_W-1:0]        cfg_o,
    output logic [NUM_EP*DATA_W-1:0] ep_cfg_o
);
    localparam int REG_COUNT = REG_EP_BASE + NUM_EP;

    logic sw_rst, irq_en, rst_flag, xfer_flag;
    logic rst_active, rst_event, rst_prev, traffic_en;

    usbdev_rst_detect i_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_rst     (sw_rst),
        .bus_rst    (bus_rst_det),
        .rst_active (rst_active),
        .rst_event  (rst_event),
        .rst_prev   (rst_prev)
    );

    usbdev_rst_ctrl_regs #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .FADDR_W (FADDR_W)
    ) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .rst_active (rst_active),
        .rst_event  (rst_event),
        .xfer_ok    (xfer_ok),
        .traffic_en (traffic_en),
        .sw_rst     (sw_rst),
        .irq_en     (irq_en),
        .rst_flag   (rst_flag),
        .xfer_flag  (xfer_flag),
        .faddr      (faddr_o),
        .cfg        (cfg_o)
    );

    usbdev_rst_ep_bank #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .NUM_EP (NUM_EP)
    ) i_ep (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .clear   (rst_active),
        .ep_flat (ep_cfg_o)
    );

    // traffic opens only after the flag is acknowledged and the reset has ended
    assign traffic_en = ~rst_flag & ~rst_prev;
    assign rx_en      = traffic_en;
    assign tx_en      = traffic_en;
    assign proto_rst  = rst_active;
    assign irq        = rst_flag & irq_en;

    // read mux over all register words
    always_comb begin
        rd_data = '0;
        if (addr == ADDR_W'(REG_CTRL)) begin
            rd_data[CTRL_SWRST_BIT] = sw_rst;
            rd_data[CTRL_IRQEN_BIT] = irq_en;
        end else if (addr == ADDR_W'(REG_STATUS)) begin
            rd_data[STAT_RST_BIT]  = rst_flag;
            rd_data[STAT_XFER_BIT] = xfer_flag;
        end else if (addr == ADDR_W'(REG_FADDR)) begin
            rd_data[FADDR_W-1:0] = faddr_o;
        end else if (addr == ADDR_W'(REG_CFG)) begin
            rd_data = cfg_o;
        end else begin
            for (int i = 0; i < NUM_EP; i++) begin
                if (addr == ADDR_W'(REG_EP_BASE + i))
                    rd_data = ep_cfg_o[i*DATA_W +: DATA_W];
            end
        end
    end

    // a register map larger than the address space would alias words
    initial begin
        if (REG_COUNT > (1 << ADDR_W))
            $display("usbdev_rst_seq: NUM_EP too large for ADDR_W");
    end
endmodule

// File: rtl/usbdev_rst_seq_chk.sv
// Checker for the reset sequencer, attached to the top by bind. It watches
// the ports and the flag register that the register block drives.
module usbdev_rst_seq_chk
    import usbdev_rst_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 4,
    parameter int FADDR_W = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic               bus_rst_det,
    input logic               proto_rst,
    input logic               rst_flag,
    input logic               irq,
    input logic               rx_en,
    input logic               tx_en,
    input logic [FADDR_W-1:0] faddr_o,
    input logic [DATA_W-1:0]  cfg_o
);
    // R2
    bus_holds_proto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_det |-> proto_rst);

    // R6
    flag_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proto_rst) |=> rst_flag);

    // R5
    gate_while_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_flag |-> (!rx_en && !tx_en));

    // R3
    faddr_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_rst |=> (faddr_o == '0));

    // R4
    cfg_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR_W'(REG_CFG)) |=> $stable(cfg_o));

    // R7
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rst_flag);
endmodule

bind usbdev_rst_seq usbdev_rst_seq_chk #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .FADDR_W (FADDR_W)
) i_usbdev_rst_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .bus_rst_det (bus_rst_det),
    .proto_rst   (proto_rst),
    .rst_flag    (rst_flag),
    .irq         (irq),
    .rx_en       (rx_en),
    .tx_en       (tx_en),
    .faddr_o     (faddr_o),
    .cfg_o       (cfg_o)
);

// File: tb/test_usbdev_rst_seq.sv
// Bench: directed reset scenarios followed by seeded random register and
// bus-reset traffic, checked against a model kept by the bench.
module test_usbdev_rst_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int FADDR_W = 7;
    localparam int NUM_EP  = 4;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     wr_en = 1'b0;
    logic [ADDR_W-1:0]        addr = '0;
    logic [DATA_W-1:0]        wr_data = '0;
    logic [DATA_W-1:0]        rd_data;
    logic                     bus_rst_det = 1'b0;
    logic                     xfer_ok = 1'b0;
    logic                     proto_rst, rx_en, tx_en, irq;
    logic [FADDR_W-1:0]       faddr_o;
    logic [DATA_W-1:0]        cfg_o;
    logic [NUM_EP*DATA_W-1:0] ep_cfg_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [DATA_W-1:0]  exp_cfg;
    logic [FADDR_W-1:0] exp_faddr;
    logic [DATA_W-1:0]  exp_ep [NUM_EP];
    logic               exp_flag;
    logic [DATA_W-1:0]  v;

    always #(CLK_PERIOD/2) clk = ~clk;

    usbdev_rst_seq #(
        .DATA_W (DATA_W), .ADDR_W (ADDR_W), .FADDR_W (FADDR_W), .NUM_EP (NUM_EP)
    ) i_usbdev_rst_seq (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr),
        .wr_data (wr_data), .rd_data (rd_data), .bus_rst_det (bus_rst_det),
        .xfer_ok (xfer_ok), .proto_rst (proto_rst), .rx_en (rx_en),
        .tx_en (tx_en), .irq (irq), .faddr_o (faddr_o), .cfg_o (cfg_o),
        .ep_cfg_o (ep_cfg_o)
    );

    function automatic logic exp_gate(input logic flag);
        return ~flag;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_W'(a); wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [DATA_W-1:0] d);
        addr = ADDR_W'(a);
        #1;
        d = rd_data;
    endtask

    task automatic bus_pulse(input int len);
        @(negedge clk);
        bus_rst_det = 1'b1;
        repeat (len) @(negedge clk);
        bus_rst_det = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9 and R5: state out of power-up reset
        for (int a = 0; a < REG_EP_BASE_L + NUM_EP; a++) begin
            rd(a, v);
            chk($sformatf("R9 reg %0d after reset", a), v, 0);
        end
        chk("R5 rx_en after reset", rx_en, 1);
        chk("R5 tx_en after reset", tx_en, 1);
        chk("R7 irq after reset", irq, 0);
        chk("R2 proto_rst after reset", proto_rst, 0);

        wr(2, 8'h35);
        wr(3, 8'hA5);
        wr(5, 8'h3C);
        rd(2, v); chk("R3 faddr written", v, 8'h35);

        // R8 and R1: bus reset with a completion in the same cycle
        @(negedge clk);
        bus_rst_det = 1'b1; xfer_ok = 1'b1;
        #1 chk("R2 proto_rst follows bus reset", proto_rst, 1);
        @(negedge clk);
        bus_rst_det = 1'b0; xfer_ok = 1'b0;
        rd(1, v);
        chk("R6 flag set by bus reset", v[0], 1);
        chk("R8 completion posted in detect cycle", v[1], 1);
        chk("R5 rx gated after bus reset", rx_en, 0);
        chk("R5 tx gated after bus reset", tx_en, 0);
        rd(2, v); chk("R1 bus reset clears faddr", v, 0);
        rd(5, v); chk("R3 bus reset clears endpoint 1", v, 0);
        rd(3, v); chk("R4 cfg kept over bus reset", v, 8'hA5);
        chk("R7 irq masked", irq, 0);

        wr(1, 8'hFF);
        rd(1, v); chk("R6 writing one keeps flag", v[0], 1);
        wr(0, 8'h02);
        chk("R7 irq with flag and enable", irq, 1);
        wr(1, 8'h02);
        rd(1, v);
        chk("R6 writing zero clears flag", v[0], 0);
        chk("R8 completion flag kept by writing one", v[1], 1);
        chk("R7 irq drops with flag", irq, 0);
        chk("R5 rx reopened", rx_en, 1);
        wr(1, 8'h00);
        rd(1, v); chk("R8 completion flag cleared", v[1], 0);

        // R1 and R2: software reset with the same effects
        wr(2, 8'h11);
        wr(4, 8'h77);
        wr(0, 8'h03);
        chk("R2 proto_rst with software bit", proto_rst, 1);
        @(posedge clk); @(negedge clk);
        rd(1, v); chk("R1 software reset sets flag", v[0], 1);
        rd(2, v); chk("R1 software reset clears faddr", v, 0);
        rd(4, v); chk("R1 software reset clears endpoint 0", v, 0);
        chk("R1 software reset gates rx", rx_en, 0);
        wr(2, 8'h22);
        rd(2, v); chk("R3 faddr write ignored in reset", v, 0);
        repeat (4) @(negedge clk);
        chk("R2 proto_rst held while bit set", proto_rst, 1);
        wr(0, 8'h02);
        chk("R2 proto_rst ends after clear", proto_rst, 0);
        chk("R5 still gated until flag cleared", rx_en, 0);
        rd(3, v); chk("R4 cfg kept over software reset", v, 8'hA5);
        wr(1, 8'h00);
        chk("R5 rx reopened after acknowledge", rx_en, 1);

        // random phase: config writes, address and endpoint writes, bus resets, clears
        exp_cfg = 8'hA5; exp_faddr = '0; exp_flag = 1'b0;
        for (int i = 0; i < NUM_EP; i++) exp_ep[i] = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            rd(REG_EP_BASE_L + i, v);
            exp_ep[i] = v;
        end
        for (int it = 0; it < 300; it++) begin
            int op;
            logic [DATA_W-1:0] d;
            op = int'($urandom % 5);
            d  = DATA_W'($urandom);
            case (op)
                0: begin wr(3, d); exp_cfg = d; end
                1: begin wr(2, d); exp_faddr = d[FADDR_W-1:0]; end
                2: begin
                    bus_pulse(1 + int'($urandom % 3));
                    exp_faddr = '0; exp_flag = 1'b1;
                    for (int i = 0; i < NUM_EP; i++) exp_ep[i] = '0;
                end
                3: begin wr(1, 8'h00); exp_flag = 1'b0; end
                default: begin
                    int e;
                    e = int'($urandom % NUM_EP);
                    wr(REG_EP_BASE_L + e, d); exp_ep[e] = d;
                end
            endcase
            rd(3, v); chk("R4 random cfg", v, exp_cfg);
            rd(2, v); chk("R3 random faddr", v, 32'(exp_faddr));
            rd(1, v); chk("R6 random flag", v[0], exp_flag);
            chk("R5 random gate", rx_en, exp_gate(exp_flag));
            chk("R7 random irq", irq, exp_flag);
            for (int i = 0; i < NUM_EP; i++) begin
                rd(REG_EP_BASE_L + i, v);
                chk("R3 random endpoint", v, exp_ep[i]);
            end
        end

        done = 1;
        report();
    end

    localparam int REG_EP_BASE_L = 4;
endmodule